// File: doc/BRIEF.md
# Bus-Matching Memory Port

This block wraps a memory whose stored words are 36 bits wide, built from four 9-bit lanes, and presents it through one port whose external width is chosen by two static configuration inputs. The port can move a full 36-bit long-word per access, an 18-bit word, or a single 9-bit byte. In the narrow widths the word-select and byte-select inputs act as extra low-order address bits. They pick which lanes of the stored long-word are read or written, and the narrow data always travels on the lowest data pins. A fourth setting keeps the port enabled but blocks every data transfer and holds all data pins in the high-impedance state.

Narrow writes update only the chosen lanes and leave the rest of the stored long-word unchanged. Reads return one cycle later, together with a per-pin output-enable vector that marks which data pins should be driven. A second, always full-width port lets a test environment, or a wide neighbour, fill and inspect whole long-words.

Top module: `bm_port`

## Requirements
- R1: The width configuration `{modeNarrow, modeFine}` is only changed while reset is low. After reset, `dataOut`, `dataOe` and `fullDataOut` are all zero.
- R2: With `{modeNarrow, modeFine}` = 00 (long-word), one access writes or reads all 36 bits at `addr`, `wordSel` and `byteSel` have no effect, and a read drives `dataOe` all ones.
- R3: With `{modeNarrow, modeFine}` = 01 (port disabled), narrow writes leave the stored long-word unchanged and `dataOe` stays all zero even while `chipEn` is high.
- R4: With `{modeNarrow, modeFine}` = 10 (word), data moves on pins 17..0. `wordSel`=1 selects stored bits 35..18 (lanes 3 and 2) and `wordSel`=0 selects bits 17..0 (lanes 1 and 0). `byteSel` has no effect.
- R5: With `{modeNarrow, modeFine}` = 11 (byte), data moves on pins 8..0, and `{wordSel, byteSel}` = 11, 10, 01 or 00 selects lane 3 (bits 35..27), lane 2, lane 1 or lane 0 (bits 8..0).
- R6: A narrow write changes only the selected lanes of the addressed long-word, and the data pins above the active width are ignored on writes.
- R7: A narrow read (`chipEn`=1, `wrEn`=0) presents its data on `dataOut` in the following cycle, with unused lanes of `dataOut` zero. `dataOe` is set on the active pins only in that cycle. It is zero after write cycles and after idle cycles.
- R8: The full port writes all 36 bits when `fullEn` and `fullWr` are high. When `fullEn` is high and `fullWr` is low it reads, and the long-word appears on `fullDataOut` one cycle later.
- R9: When both ports write the same address in the same cycle, the lanes chosen by the narrow port take the narrow data and the other lanes take the full-port data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the output registers |
| modeNarrow | input | 1 | Static configuration: 1 selects a narrow width |
| modeFine | input | 1 | Static configuration: byte width when narrow, port disable when wide |
| chipEn | input | 1 | Access strobe for the bus-matched port |
| wrEn | input | 1 | 1 = write, 0 = read on the bus-matched port |
| addr | input | 6 | Long-word address of the bus-matched port |
| wordSel | input | 1 | Extra address bit choosing the upper or lower half |
| byteSel | input | 1 | Extra address bit choosing a lane within the half (byte width) |
| dataIn | input | 36 | Write data of the bus-matched port |
| dataOut | output | 36 | Registered read data of the bus-matched port |
| dataOe | output | 36 | Per-pin output enable for `dataOut` |
| fullEn | input | 1 | Access strobe for the full-width port |
| fullWr | input | 1 | 1 = write, 0 = read on the full-width port |
| fullAddr | input | 6 | Long-word address of the full-width port |
| fullDataIn | input | 36 | Write data of the full-width port |
| fullDataOut | output | 36 | Registered read data of the full-width port |

## Verification
The hardest case to reach is a collision of the two ports. Both must write the same long-word in the same cycle, and only the lane-level merge shows whether the narrow lanes took priority without erasing the neighbouring full-port lanes. The bench drives both ports in a single clock period to create it. It also checks the lane-isolation property more generally: each narrow write lands on a known background that the full port wrote first, and every byte of that background differs from the others, so any stray lane write shows up in the full-width readback. A mode change is only possible through reset, and memory is not reset, so the bench reads data across modes written in an earlier mode.

// File: rtl/bm_pkg.sv
package bm_pkg;

  localparam int NUM_LANES  = 4;
  localparam int LANE_IDX_W = $clog2(NUM_LANES);

  typedef enum logic [1:0] {
    MODE_LONG = 2'b00,
    MODE_OFF  = 2'b01,
    MODE_WORD = 2'b10,
    MODE_BYTE = 2'b11
  } bm_mode_e;

  typedef struct packed {
    logic [NUM_LANES-1:0]  laneWe;
    logic                  rdStrobe;
    logic [LANE_IDX_W-1:0] baseLane;
    logic [NUM_LANES-1:0]  pinMask;
  } bm_strobe_t;

endpackage

// File: rtl/bm_ctrl.sv
module bm_ctrl
  import bm_pkg::*;
(
  input  logic       modeNarrow,
  input  logic       modeFine,
  input  logic       chipEn,
  input  logic       wrEn,
  input  logic       wordSel,
  input  logic       byteSel,
  output bm_strobe_t strb
);

  bm_mode_e              mode;
  logic [LANE_IDX_W-1:0] base;
  logic [NUM_LANES-1:0]  mask;
  logic                  access;
  logic [LANE_IDX_W-1:0] rel;

  always_comb begin
    mode = bm_mode_e'({modeNarrow, modeFine});
    base = '0;
    mask = '0;
    unique case (mode)
      MODE_LONG: mask = {NUM_LANES{1'b1}};
      MODE_WORD: begin
        base = {wordSel, 1'b0};
        mask = 4'b0011;
      end
      MODE_BYTE: begin
        base = {wordSel, byteSel};
        mask = 4'b0001;
      end
      default: mask = '0;
    endcase
  end

  assign access = chipEn && (mode != MODE_OFF);

  always_comb begin
    rel = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      rel            = LANE_IDX_W'(l) - base;
      strb.laneWe[l] = access && wrEn && mask[rel];
    end
    strb.rdStrobe = access && !wrEn;
    strb.baseLane = base;
    strb.pinMask  = mask;
  end

endmodule

// File: rtl/bm_datapath.sv
module bm_datapath
  import bm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  bm_strobe_t                    strb,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [NUM_LANES*LANE_W-1:0]   dataIn,
  input  logic                          fullEn,
  input  logic                          fullWr,
  input  logic [ADDR_W-1:0]             fullAddr,
  input  logic [NUM_LANES*LANE_W-1:0]   fullDataIn,
  output logic [NUM_LANES*LANE_W-1:0]   dataOut,
  output logic [NUM_LANES*LANE_W-1:0]   dataOe,
  output logic [NUM_LANES*LANE_W-1:0]   fullDataOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [NUM_LANES-1:0][LANE_W-1:0] inLanes;
  logic [NUM_LANES-1:0][LANE_W-1:0] fullInLanes;
  logic [NUM_LANES-1:0][LANE_W-1:0] wrLanes;
  logic [NUM_LANES-1:0][LANE_W-1:0] rawNarrow;
  logic [NUM_LANES-1:0][LANE_W-1:0] rawFull;
  logic [NUM_LANES-1:0][LANE_W-1:0] rdLanes;
  logic [NUM_LANES-1:0][LANE_W-1:0] oeLanes;
  logic                             fullWe;
  logic [LANE_IDX_W-1:0]            srcIdx;
  logic [LANE_IDX_W-1:0]            memIdx;

  assign inLanes     = dataIn;
  assign fullInLanes = fullDataIn;
  assign fullWe      = fullEn && fullWr;

  // Narrow data sits on the low pins; lane l takes pin-lane (l - base).
  always_comb begin
    srcIdx = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      srcIdx     = LANE_IDX_W'(l) - strb.baseLane;
      wrLanes[l] = inLanes[srcIdx];
    end
  end

  // Read path rotates the stored lanes down to the pins and masks the rest.
  always_comb begin
    memIdx = '0;
    for (int j = 0; j < NUM_LANES; j++) begin
      memIdx     = LANE_IDX_W'(j) + strb.baseLane;
      rdLanes[j] = strb.pinMask[j] ? rawNarrow[memIdx] : '0;
      oeLanes[j] = {LANE_W{strb.pinMask[j]}};
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];

    // Full-port write first; a narrow write to the same word overrides it.
    always_ff @(posedge clk) begin
      if (fullWe)         laneMem[fullAddr] <= fullInLanes[g];
      if (strb.laneWe[g]) laneMem[addr]     <= wrLanes[g];
    end

    assign rawNarrow[g] = laneMem[addr];
    assign rawFull[g]   = laneMem[fullAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut     <= '0;
      dataOe      <= '0;
      fullDataOut <= '0;
    end else begin
      if (strb.rdStrobe) begin
        dataOut <= rdLanes;
        dataOe  <= oeLanes;
      end else begin
        dataOe  <= '0;
      end
      if (fullEn && !fullWr) fullDataOut <= rawFull;
    end
  end

endmodule

// File: rtl/bm_port.sv
module bm_port
  import bm_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        modeNarrow,
  input  logic                        modeFine,
  input  logic                        chipEn,
  input  logic                        wrEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wordSel,
  input  logic                        byteSel,
  input  logic [NUM_LANES*LANE_W-1:0] dataIn,
  output logic [NUM_LANES*LANE_W-1:0] dataOut,
  output logic [NUM_LANES*LANE_W-1:0] dataOe,
  input  logic                        fullEn,
  input  logic                        fullWr,
  input  logic [ADDR_W-1:0]           fullAddr,
  input  logic [NUM_LANES*LANE_W-1:0] fullDataIn,
  output logic [NUM_LANES*LANE_W-1:0] fullDataOut
);

  bm_strobe_t strb;

  bm_ctrl u_ctrl (
    .modeNarrow(modeNarrow),
    .modeFine  (modeFine),
    .chipEn    (chipEn),
    .wrEn      (wrEn),
    .wordSel   (wordSel),
    .byteSel   (byteSel),
    .strb      (strb)
  );

  bm_datapath #(
    .ADDR_W(ADDR_W),
    .LANE_W(LANE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .addr       (addr),
    .dataIn     (dataIn),
    .fullEn     (fullEn),
    .fullWr     (fullWr),
    .fullAddr   (fullAddr),
    .fullDataIn (fullDataIn),
    .dataOut    (dataOut),
    .dataOe     (dataOe),
    .fullDataOut(fullDataOut)
  );

endmodule

// File: rtl/bm_port_chk.sv
module bm_port_chk
  import bm_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        modeNarrow,
  input logic                        modeFine,
  input logic                        chipEn,
  input logic                        wrEn,
  input logic [NUM_LANES*LANE_W-1:0] dataOe
);

  localparam int DATA_W = NUM_LANES * LANE_W;

  p_cfg_static_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable({modeNarrow, modeFine}))
    else $error("configuration changed outside reset");

  p_long_oe_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && {modeNarrow, modeFine} == MODE_LONG && $past(chipEn && !wrEn))
      |-> dataOe == {DATA_W{1'b1}})
    else $error("long-word read did not enable all pins");

  p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    ({modeNarrow, modeFine} == MODE_OFF) |-> dataOe == '0)
    else $error("disabled port enabled a pin");

  p_word_pins_r4: assert property (@(posedge clk) disable iff (!rstN)
    ({modeNarrow, modeFine} == MODE_WORD) |-> dataOe[DATA_W-1:2*LANE_W] == '0)
    else $error("word width enabled an upper pin");

  p_byte_pins_r5: assert property (@(posedge clk) disable iff (!rstN)
    ({modeNarrow, modeFine} == MODE_BYTE) |-> dataOe[DATA_W-1:LANE_W] == '0)
    else $error("byte width enabled a pin above lane 0");

  p_oe_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(chipEn && !wrEn) |-> dataOe == '0)
    else $error("output enable without a read");

endmodule

bind bm_port bm_port_chk #(.LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .modeNarrow(modeNarrow),
  .modeFine  (modeFine),
  .chipEn    (chipEn),
  .wrEn      (wrEn),
  .dataOe    (dataOe)
);

// File: tb/tb_bm_port.sv
module tb_bm_port;

  localparam int CLK_PERIOD = 10;

  localparam logic [8:0] L3 = 9'h1A3;
  localparam logic [8:0] L2 = 9'h0B2;
  localparam logic [8:0] L1 = 9'h0C1;
  localparam logic [8:0] L0 = 9'h0D0;
  localparam logic [8:0] FILL = 9'h1FF;
  localparam logic [35:0] BG = {L3, L2, L1, L0};
  localparam logic [35:0] ONES = {36{1'b1}};

  typedef struct packed {
    logic [1:0]  mode;
    logic        wa;
    logic        ba;
    logic [35:0] wd;
    logic [35:0] expFull;
    logic [35:0] expRd;
    logic [35:0] expOe;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'b00, 1'b1, 1'b0, {9'h011, 9'h022, 9'h033, 9'h044},
      {9'h011, 9'h022, 9'h033, 9'h044}, {9'h011, 9'h022, 9'h033, 9'h044}, ONES},
    '{2'b10, 1'b0, 1'b1, {FILL, FILL, 9'h055, 9'h066},
      {L3, L2, 9'h055, 9'h066}, {18'h0, 9'h055, 9'h066}, {18'h0, {18{1'b1}}}},
    '{2'b10, 1'b1, 1'b0, {FILL, FILL, 9'h077, 9'h088},
      {9'h077, 9'h088, L1, L0}, {18'h0, 9'h077, 9'h088}, {18'h0, {18{1'b1}}}},
    '{2'b11, 1'b0, 1'b0, {FILL, FILL, FILL, 9'h099},
      {L3, L2, L1, 9'h099}, {27'h0, 9'h099}, {27'h0, 9'h1FF}},
    '{2'b11, 1'b0, 1'b1, {FILL, FILL, FILL, 9'h0AA},
      {L3, L2, 9'h0AA, L0}, {27'h0, 9'h0AA}, {27'h0, 9'h1FF}},
    '{2'b11, 1'b1, 1'b0, {FILL, FILL, FILL, 9'h0BB},
      {L3, 9'h0BB, L1, L0}, {27'h0, 9'h0BB}, {27'h0, 9'h1FF}},
    '{2'b11, 1'b1, 1'b1, {FILL, FILL, FILL, 9'h0CC},
      {9'h0CC, L2, L1, L0}, {27'h0, 9'h0CC}, {27'h0, 9'h1FF}},
    '{2'b01, 1'b1, 1'b1, {9'h011, 9'h022, 9'h033, 9'h044},
      BG, 36'h0, 36'h0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeNarrow = 1'b0;
  logic        modeFine = 1'b0;
  logic        chipEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  addr = '0;
  logic        wordSel = 1'b0;
  logic        byteSel = 1'b0;
  logic [35:0] dataIn = '0;
  logic [35:0] dataOut;
  logic [35:0] dataOe;
  logic        fullEn = 1'b0;
  logic        fullWr = 1'b0;
  logic [5:0]  fullAddr = '0;
  logic [35:0] fullDataIn = '0;
  logic [35:0] fullDataOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bm_port dut (
    .clk(clk), .rstN(rstN), .modeNarrow(modeNarrow), .modeFine(modeFine),
    .chipEn(chipEn), .wrEn(wrEn), .addr(addr), .wordSel(wordSel),
    .byteSel(byteSel), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .fullEn(fullEn), .fullWr(fullWr), .fullAddr(fullAddr),
    .fullDataIn(fullDataIn), .fullDataOut(fullDataOut)
  );

  task automatic check(string req, string what, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string modeTag(logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic doReset(logic [1:0] m);
    @(negedge clk);
    rstN = 1'b0;
    chipEn = 1'b0;
    fullEn = 1'b0;
    {modeNarrow, modeFine} = m;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic fullWrite(logic [5:0] a, logic [35:0] d);
    @(negedge clk);
    fullEn = 1'b1; fullWr = 1'b1; fullAddr = a; fullDataIn = d;
    @(negedge clk);
    fullEn = 1'b0; fullWr = 1'b0;
  endtask

  task automatic fullRead(logic [5:0] a, output logic [35:0] d);
    @(negedge clk);
    fullEn = 1'b1; fullWr = 1'b0; fullAddr = a;
    @(negedge clk);
    fullEn = 1'b0;
    d = fullDataOut;
  endtask

  task automatic narrowWrite(logic [5:0] a, logic wa, logic ba, logic [35:0] d);
    @(negedge clk);
    chipEn = 1'b1; wrEn = 1'b1; addr = a; wordSel = wa; byteSel = ba; dataIn = d;
    @(negedge clk);
    chipEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic narrowRead(logic [5:0] a, logic wa, logic ba,
                            output logic [35:0] d, output logic [35:0] oe);
    @(negedge clk);
    chipEn = 1'b1; wrEn = 1'b0; addr = a; wordSel = wa; byteSel = ba;
    @(negedge clk);
    chipEn = 1'b0;
    d = dataOut;
    oe = dataOe;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [35:0] rd;
    logic [35:0] oe;
    logic [1:0]  curMode;

    // R1: outputs after reset
    curMode = 2'b00;
    doReset(curMode);
    @(negedge clk);
    check("R1", "dataOut after reset", dataOut, 36'h0);
    check("R1", "dataOe after reset", dataOe, 36'h0);
    check("R1", "fullDataOut after reset", fullDataOut, 36'h0);

    // Table walk: background by full port, narrow write, readback both ways
    for (int i = 0; i < 8; i++) begin
      if (VECS[i].mode != curMode) begin
        curMode = VECS[i].mode;
        doReset(curMode);
      end
      fullWrite(6'(i + 1), BG);
      narrowWrite(6'(i + 1), VECS[i].wa, VECS[i].ba, VECS[i].wd);
      fullRead(6'(i + 1), rd);
      check({modeTag(VECS[i].mode), " R6 R8"}, $sformatf("vec %0d full readback", i),
            rd, VECS[i].expFull);
      narrowRead(6'(i + 1), VECS[i].wa, VECS[i].ba, rd, oe);
      check({modeTag(VECS[i].mode), " R7"}, $sformatf("vec %0d narrow data", i),
            rd, VECS[i].expRd);
      check({modeTag(VECS[i].mode), " R7"}, $sformatf("vec %0d output enable", i),
            oe, VECS[i].expOe);
    end

    // R3: disabled port stays quiet even with a read held active
    @(negedge clk);
    chipEn = 1'b1; wrEn = 1'b0; addr = 6'd8;
    @(negedge clk);
    check("R3", "dataOe during held read when disabled", dataOe, 36'h0);
    chipEn = 1'b0;

    // R5: full-width data read back lane by lane in byte width
    curMode = 2'b11;
    doReset(curMode);
    fullWrite(6'd40, BG);
    for (int k = 0; k < 4; k++) begin
      narrowRead(6'd40, k[1], k[0], rd, oe);
      check("R5", $sformatf("byte lane %0d read", k), rd, {27'h0, BG[k*9 +: 9]});
    end

    // R7: enables drop after the read cycle and on write/idle cycles
    narrowRead(6'd40, 1'b0, 1'b0, rd, oe);
    @(negedge clk);
    check("R7", "dataOe after idle cycle", dataOe, 36'h0);
    narrowWrite(6'd41, 1'b0, 1'b0, {27'h0, 9'h012});
    check("R7", "dataOe after write cycle", dataOe, 36'h0);

    // R9: both ports write one long-word in the same cycle
    @(negedge clk);
    fullEn = 1'b1; fullWr = 1'b1; fullAddr = 6'd42;
    fullDataIn = {9'h101, 9'h102, 9'h103, 9'h104};
    chipEn = 1'b1; wrEn = 1'b1; addr = 6'd42; wordSel = 1'b1; byteSel = 1'b0;
    dataIn = {FILL, FILL, FILL, 9'h0EE};
    @(negedge clk);
    fullEn = 1'b0; fullWr = 1'b0; chipEn = 1'b0; wrEn = 1'b0;
    fullRead(6'd42, rd);
    check("R9", "collision merge", rd, {9'h101, 9'h0EE, 9'h103, 9'h104});

    // R4: word width reads halves of data written in byte width, byteSel ignored
    curMode = 2'b10;
    doReset(curMode);
    narrowRead(6'd40, 1'b1, 1'b1, rd, oe);
    check("R4", "upper half read", rd, {18'h0, L3, L2});
    narrowRead(6'd40, 1'b0, 1'b1, rd, oe);
    check("R4", "lower half read", rd, {18'h0, L1, L0});

    // R2: long-word read ignores the select inputs
    curMode = 2'b00;
    doReset(curMode);
    narrowRead(6'd40, 1'b1, 1'b1, rd, oe);
    check("R2", "long-word read with selects set", rd, BG);
    check("R2", "long-word output enable", oe, ONES);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule